// File: doc/BRIEF.md
# Saturating Rounding Shift Unit

This block is a packed-lane shifter. One data word is split into equal lanes of 8, 16, 32 or 64 bits, and each lane is shifted by its own signed amount. The amount is the low byte of the matching lane of a second word, read as a two's-complement number. A positive amount shifts the lane left. If bits would be lost, the lane saturates instead. A negative amount gives a right shift rounded to nearest, with ties rounded upward. A right shift never saturates. A select input chooses whether the lanes are read as signed or unsigned.

The result is registered on an input strobe and is held until the next strobe. A sticky saturation flag records whether any lane of any strobed operation has saturated since the flag was last cleared. The flag is a two-state machine:

- `FLAG_CLEAR` moves to `FLAG_SET` on the *hit* transition (strobe with a saturating lane and no clear).
- `FLAG_SET` returns to `FLAG_CLEAR` on the *clear* transition (clear input high).
- Clear always wins over a hit in the same cycle.

Top module: `rnd_shift_sat`

## Requirements
- R1: `lsize_i` picks the lane width: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64. Lane i is bits [i*L +: L] of the word. Its amount is bits [i*L +: 8] of `shamt_i`, read as signed. The other bits of the lane's shift field are ignored, and lanes do not affect one another.
- R2: A positive amount a that loses no significant bits gives the lane value shifted left by a.
- R3: An amount of -n (n from 1 to 128) gives floor((v + 2^(n-1)) / 2^n), computed exactly on the signed or unsigned lane value. This gives 0 once n exceeds the lane width.
- R4: In unsigned mode, a left shift that loses set bits makes the lane all ones.
- R5: In signed mode, a left shift whose true result falls outside the lane range makes the lane the most positive value for a positive input, or the most negative value for a negative input.
- R6: An amount of zero passes the lane unchanged and never saturates.
- R7: Right shifts never set the saturation flag.
- R8: A strobe with any saturating lane sets `sat_o` from the next edge on. It stays set through any later non-saturating operations.
- R9: `flag_clr_i` clears `sat_o` at the next edge, with or without a strobe, and takes priority over a saturation in the same cycle.
- R10: The result appears after the edge on which `in_valid` is high and is held while `in_valid` is low. Reset gives a zero result and a clear flag.
- R11: For a 64-bit lane with amount -1, the signed maximum yields 0x4000000000000000 and the unsigned all-ones value yields 0x8000000000000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| value_i | input | W | Packed lane values |
| shamt_i | input | W | Packed lane shift fields, signed amount in each lane's low byte |
| signed_i | input | 1 | 1 = signed lanes, 0 = unsigned |
| lsize_i | input | SZW | Lane width code |
| flag_clr_i | input | 1 | Clear the sticky saturation flag |
| result_o | output | W | Registered shifted word |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
A wrong flag state shows on `sat_o` one edge after the operation that caused it. A flag that does not stick shows as a drop during the next non-saturating operation. A flag that sets wrongly shows on a run of right shifts after a clear. A wrong lane result shows on `result_o` one edge after its strobe. Every lane is compared against an exact wide-integer model, so a fault in rounding, the overflow test or the choice of saturation value shows in the first operation that reaches that case. The 8-bit sweep covers every value and amount in both modes. The wider lanes are swept across every amount near their width, with edge and pseudo-random values.

// File: rtl/srs_pkg.sv
package srs_pkg;
    localparam int AMT_W    = 8;
    localparam int MIN_LANE = 8;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;
endpackage

// File: rtl/srs_lane.sv
module srs_lane
    import srs_pkg::*;
#(
    parameter int L = 8
) (
    input  logic [L-1:0]     v,
    input  logic [AMT_W-1:0] amt,
    input  logic             sgn,
    output logic [L-1:0]     res,
    output logic             sat
);
    logic                 neg;
    logic [AMT_W-2:0]     lamt;
    logic [AMT_W-1:0]     rsh;
    logic [L-1:0]         shl;
    logic [L-1:0]         back;
    logic [L-1:0]         satv;
    logic                 ovf;
    logic signed [L:0]    ext;
    logic signed [L:0]    t;
    logic [L-1:0]         rnd;

    always_comb begin
        neg  = amt[AMT_W-1];
        lamt = amt[AMT_W-2:0];
        // For a negative amount -n, n-1 equals the bitwise inverse of the amount.
        rsh  = ~amt;

        // Left path: shift, then shift back and compare to detect lost bits.
        shl = v << lamt;
        if (sgn) back = $signed(shl) >>> lamt;
        else     back = shl >> lamt;
        ovf  = (back != v);
        satv = sgn ? {v[L-1], {(L-1){~v[L-1]}}} : {L{1'b1}};

        // Right path: one guard bit; bit 0 after shifting by n-1 is the round bit.
        ext = sgn ? {v[L-1], v} : {1'b0, v};
        t   = ext >>> rsh;
        rnd = t[L:1] + {{(L-1){1'b0}}, t[0]};

        if (neg) begin
            res = rnd;
            sat = 1'b0;
        end else if (ovf) begin
            res = satv;
            sat = 1'b1;
        end else begin
            res = shl;
            sat = 1'b0;
        end
    end

    always_comb begin
        if (amt == '0) begin
            p_zero_pass_r6: assert (res == v && !sat);
        end
    end
endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
    import srs_pkg::*;
#(
    parameter  int W   = 64,
    localparam int NSZ = $clog2(W / MIN_LANE) + 1,
    localparam int SZW = (NSZ > 1) ? $clog2(NSZ) : 1
) (
    input  logic [W-1:0]   value,
    input  logic [W-1:0]   shamt,
    input  logic           sgn,
    input  logic [SZW-1:0] lsize,
    output logic [W-1:0]   res,
    output logic           sat
);
    logic [W-1:0]   res_sz [NSZ];
    logic [NSZ-1:0] sat_sz;

    for (genvar s = 0; s < NSZ; s++) begin : g_sz
        localparam int LW = MIN_LANE << s;
        localparam int NL = W / LW;
        logic [NL-1:0] lsat;
        logic [W-1:0]  rw;
        for (genvar i = 0; i < NL; i++) begin : g_ln
            srs_lane #(.L(LW)) u_lane (
                .v   (value[i*LW +: LW]),
                .amt (shamt[i*LW +: AMT_W]),
                .sgn (sgn),
                .res (rw[i*LW +: LW]),
                .sat (lsat[i])
            );
        end
        assign res_sz[s] = rw;
        assign sat_sz[s] = |lsat;
    end

    always_comb begin
        res = res_sz[NSZ-1];
        sat = sat_sz[NSZ-1];
        for (int s = 0; s < NSZ - 1; s++) begin
            if (lsize == SZW'(s)) begin
                res = res_sz[s];
                sat = sat_sz[s];
            end
        end
    end
endmodule

// File: rtl/srs_sat_fsm.sv
module srs_sat_fsm
    import srs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (hit && !clr) state_d = FLAG_SET;
            FLAG_SET:   if (clr)         state_d = FLAG_CLEAR;
            default:                     state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_SET);
    end

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag);
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);
    p_set_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !clr |=> flag);
endmodule

// File: rtl/rnd_shift_sat.sv
module rnd_shift_sat
    import srs_pkg::*;
#(
    parameter  int W   = 64,
    localparam int NSZ = $clog2(W / MIN_LANE) + 1,
    localparam int SZW = (NSZ > 1) ? $clog2(NSZ) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [W-1:0]   value_i,
    input  logic [W-1:0]   shamt_i,
    input  logic           signed_i,
    input  logic [SZW-1:0] lsize_i,
    input  logic           flag_clr_i,
    output logic [W-1:0]   result_o,
    output logic           sat_o
);
    logic [W-1:0] dp_res;
    logic         dp_sat;
    logic [W-1:0] res_q;
    logic         hit;

    srs_datapath #(.W(W)) u_dp (
        .value (value_i),
        .shamt (shamt_i),
        .sgn   (signed_i),
        .lsize (lsize_i),
        .res   (dp_res),
        .sat   (dp_sat)
    );

    assign hit = in_valid & dp_sat;

    srs_sat_fsm u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (flag_clr_i),
        .flag  (sat_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        res_q <= '0;
        else if (in_valid) res_q <= dp_res;
    end

    assign result_o = res_q;

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result_o));
    p_rise_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sat_o && !hit |=> !sat_o);
endmodule

// File: tb/tb_rnd_shift_sat.sv
module tb_rnd_shift_sat;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n, in_valid, signed_i, flag_clr_i, sat_o;
    logic [W-1:0] value_i, shamt_i, result_o;
    logic [1:0]   lsize_i;

    always #10 clk = ~clk;

    rnd_shift_sat #(.W(W)) dut (
        .clk, .rst_n, .in_valid, .value_i, .shamt_i, .signed_i,
        .lsize_i, .flag_clr_i, .result_o, .sat_o
    );

    int           n_chk = 0;
    int           n_bad = 0;
    bit           flag_exp = 1'b0;
    int           opn = 0;
    logic [63:0]  last_exp;
    logic [63:0]  rs = 64'h9E37_79B9_7F4A_7C15;

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] lmask(input int L);
        return (L == 64) ? '1 : ((64'd1 << L) - 64'd1);
    endfunction

    // Exact wide-integer model of one lane
    function automatic void ref_lane(input logic [63:0] v, input logic [7:0] amt, input bit sgn,
                                     input int L, output logic [63:0] r, output bit sat, output string tag);
        logic signed [199:0] x, p, hi, lo, one;
        int a;
        one = 200'sd1;
        x = '0;
        for (int b = 0; b < L; b++) x[b] = v[b];
        if (sgn && v[L-1]) for (int b = L; b < 200; b++) x[b] = 1'b1;
        a = int'($signed(amt));
        sat = 1'b0;
        if (sgn) begin hi = (one <<< (L-1)) - one; lo = -(one <<< (L-1)); end
        else     begin hi = (one <<< L) - one;     lo = '0; end
        if (a < 0) begin
            p = (x + (one <<< (-a - 1))) >>> (-a);
            tag = (L == 64 && a == -1 && x == hi) ? "R11" : "R3";
        end else begin
            p = x <<< a;
            if (p > hi || p < lo) begin
                sat = 1'b1;
                p = (sgn && x < 0) ? lo : hi;
                tag = sgn ? "R5" : "R4";
            end else begin
                tag = (a == 0) ? "R6" : "R2";
            end
        end
        r = p[63:0] & lmask(L);
    endfunction

    // One strobed operation starting at a falling edge; checks at the next falling edge
    task automatic run_op(input logic [63:0] val, input logic [63:0] sh, input bit sgn,
                          input int szc, input bit clr);
        logic [63:0] el [8];
        string       tl [8];
        logic [63:0] r, m, got;
        bit          s, any_sat, all_neg;
        string       t;
        int          L, nl;
        L = 8 << szc;
        nl = W / L;
        m = lmask(L);
        any_sat = 1'b0;
        all_neg = 1'b1;
        last_exp = '0;
        for (int i = 0; i < nl; i++) begin
            ref_lane(val >> (i*L), sh[i*L +: 8], sgn, L, r, s, t);
            el[i] = r;
            tl[i] = t;
            any_sat |= s;
            if (!sh[i*L + 7]) all_neg = 1'b0;
            last_exp |= r << (i*L);
        end
        value_i = val; shamt_i = sh; signed_i = sgn; lsize_i = szc[1:0];
        flag_clr_i = clr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; flag_clr_i = 1'b0;
        if (clr) flag_exp = 1'b0;
        else if (any_sat) flag_exp = 1'b1;
        for (int i = 0; i < nl; i++) begin
            got = (result_o >> (i*L)) & m;
            chk(got == el[i], $sformatf("%s lane%0d L=%0d sgn=%0d amt=%0d", tl[i], i, L, sgn,
                $signed(sh[i*L +: 8])), got, el[i]);
        end
        chk(sat_o == flag_exp, (all_neg && !clr) ? "R7 flag" : (clr ? "R9 flag" : "R8 flag"),
            64'(sat_o), 64'(flag_exp));
        opn++;
    endtask

    function automatic logic [63:0] rep(input logic [63:0] lp, input int L);
        logic [63:0] w;
        w = '0;
        for (int i = 0; i < W / L; i++) w |= (lp & lmask(L)) << (i*L);
        return w;
    endfunction

    function automatic logic [63:0] shw(input int a, input int L);
        logic [63:0] w;
        logic [7:0]  b;
        w = {8{8'hA5}};
        for (int i = 0; i < W / L; i++) begin
            b = (i % 2 == 1) ? 8'(-a) : 8'(a);
            w[i*L +: 8] = b;
        end
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog got=running exp=finished");
        finish_run();
    end

    initial begin
        logic [63:0] held, pv, vw;
        rst_n = 1'b0; in_valid = 1'b0; signed_i = 1'b0; flag_clr_i = 1'b0;
        value_i = '0; shamt_i = '0; lsize_i = '0;
        repeat (3) @(negedge clk);
        chk(result_o == '0, "R10 reset result", result_o, 64'd0);
        chk(sat_o == 1'b0, "R10 reset flag", 64'(sat_o), 64'd0);
        rst_n = 1'b1;

        // R11: half-range results on 64-bit lanes
        run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'hFF, 1'b1, 3, 1'b0);
        chk(result_o == 64'h4000_0000_0000_0000, "R11 signed", result_o, 64'h4000_0000_0000_0000);
        run_op('1, 64'hFF, 1'b0, 3, 1'b0);
        chk(result_o == 64'h8000_0000_0000_0000, "R11 unsigned", result_o, 64'h8000_0000_0000_0000);

        // R10: result held while strobe low
        held = result_o;
        value_i = 64'h1234_5678_9ABC_DEF0; shamt_i = '0;
        @(negedge clk);
        chk(result_o == held, "R10 hold", result_o, held);

        // R1: mixed amounts in 16-bit lanes with junk in upper shift bits
        run_op(64'h8001_7FFF_0003_00F0, 64'hABFE_CD01_EF02_12FC, 1'b1, 1, 1'b0);
        chk(result_o == last_exp, "R1 word", result_o, last_exp);

        // R9: clear beats a saturation in the same cycle, then clear alone
        run_op(rep(64'h40, 8), 64'h0202_0202_0202_0202, 1'b1, 0, 1'b1);
        run_op(rep(64'h40, 8), 64'h0202_0202_0202_0202, 1'b1, 0, 1'b0);
        flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0;
        flag_exp = 1'b0;
        chk(sat_o == 1'b0, "R9 clear alone", 64'(sat_o), 64'd0);

        // R7: right shifts of extreme values leave the flag clear
        run_op('1, '1, 1'b0, 0, 1'b0);
        run_op(64'h8000_0000_0000_0000, 64'h80, 1'b1, 3, 1'b0);

        // R8: saturate once, then non-saturating ops keep the flag set
        run_op(rep(64'hFFFF, 16), shw(3, 16), 1'b0, 1, 1'b0);
        for (int k = 0; k < 4; k++) run_op(64'(k * 977), '0, k[0], k % 4, 1'b0);
        chk(sat_o == 1'b1, "R8 sticky", 64'(sat_o), 64'd1);

        // Exhaustive 8-bit sweep: all values, all amounts, both modes
        for (int sg = 0; sg < 2; sg++)
            for (int a = -128; a < 128; a++)
                for (int base = 0; base < 32; base++) begin
                    vw = '0;
                    for (int j = 0; j < 8; j++) vw[j*8 +: 8] = 8'(base * 8 + j);
                    run_op(vw, shw(a, 8), sg[0], 0, (opn % 11) == 0);
                end

        // Wider lanes: every amount around the width, edge and random values
        for (int sz = 1; sz < 4; sz++) begin
            int L;
            L = 8 << sz;
            for (int sg = 0; sg < 2; sg++)
                for (int ai = -(L + 2); ai <= L + 4; ai++) begin
                    int a;
                    a = (ai == L + 3) ? -128 : ((ai == L + 4) ? 127 : ai);
                    for (int k = 0; k < 12; k++) begin
                        case (k)
                            0: pv = '0;
                            1: pv = '1;
                            2: pv = rep(lmask(L) >> 1, L);
                            3: pv = rep(64'd1 << (L - 1), L);
                            4: pv = rep(64'd1, L);
                            5: pv = rep(64'h5555_5555_5555_5555, L);
                            default: begin
                                rs = rs ^ (rs << 13); rs = rs ^ (rs >> 7); rs = rs ^ (rs << 17);
                                pv = rs;
                            end
                        endcase
                        run_op(pv, shw(a, L), sg[0], sz, (opn % 11) == 0);
                    end
                end
        end

        finish_run();
    end
endmodule